// File: doc/BRIEF.md
# Host Virtual Console Bridge

This block lets a host talk to an embedded CPU as if through a serial console, with no serial line. It has two register ports. The device port is used by the embedded CPU. The host port is used by the host.

A byte the host writes is held for the device, which reads it as received data. Only one host byte can wait at a time. Bytes the device writes go into a receive queue. The host empties that queue one byte per read. Each host read returns three things in one word: the byte, a flag saying whether the byte is valid, and how many bytes are still queued. Baud generation and physical pins are not part of the block. It is a register-level loopback between the two ports.

Both ports use single-cycle strobes. Read data is registered: it appears on the read-data port in the cycle after the read strobe. The side effects of a read (clearing a flag, popping the queue) happen on that same clock edge.

Top module: `vuart_bridge`

## Requirements
- R1: After reset, the device status reads 0. A host read of the host receive register returns 0. A host read of the host transmit register returns 0x100, meaning ready to accept with a held byte of 0.
- R2: The host writes a byte to host offset 0x10 while no byte is pending. The byte is then held, and device status bit 1 (receive ready) reads 1.
- R3: The host writes to offset 0x10 while device receive ready is 1. That write is dropped, and the byte already held is unchanged.
- R4: A device read of offset 0x0C returns the held byte in bits 7:0 and clears receive ready. Host offset 0x10 reads back the held byte in bits 7:0. Its bit 8 is 1 exactly when receive ready is 0.
- R5: A device write to offset 0x08 pushes the data byte into the host receive queue. The host reads the bytes back in first-in, first-out order.
- R6: A host read of offset 0x14 on a non-empty queue returns the head byte in bits 7:0, a 1 in bit 8, and in bits 24:9 the queue occupancy left after the pop. It also removes the head byte. All other bits read 0.
- R7: A host read of offset 0x14 on an empty queue returns 0 and changes nothing.
- R8: Device status bit 0 (transmit busy) is 1 exactly while the queue holds DEPTH bytes. A device write to 0x08 while the queue is full is dropped.
- R9: Device reads of any offset other than 0x00 and 0x0C return 0. Host reads of any offset other than 0x10 and 0x14 return 0. Writes to any offset other than device 0x08 and host 0x10 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_wr | input | 1 | Device write strobe |
| dev_rd | input | 1 | Device read strobe |
| dev_addr | input | AW | Device byte offset |
| dev_wdata | input | 8 | Device write byte |
| dev_rdata | output | 32 | Device read word, valid the cycle after dev_rd |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | AW | Host byte offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 32 | Host read word, valid the cycle after host_rd |

## Verification
The bench builds the block with DEPTH of 4 and the default AW of 5. A queue depth of 4 lets a few device writes fill the queue. That brings the transmit-busy flag, the dropped write into a full queue, and the count field stepping 3, 2, 1, 0 during a drain within reach of short directed tests. The host-to-device path is independent of depth. Those tests cover the single pending byte, the dropped second write, and the ready flag handing back to the host.

// File: rtl/vuart_pkg.sv
package vuart_pkg;
  localparam int WORD_W      = 32;
  localparam int BYTE_W      = 8;
  localparam int CNT_FIELD_W = 16;
  localparam int MAX_DEPTH   = 65535;

  // register offsets
  localparam int OFF_DEV_STATUS = 'h00;
  localparam int OFF_DEV_TXD    = 'h08;
  localparam int OFF_DEV_RXD    = 'h0C;
  localparam int OFF_HOST_TX    = 'h10;
  localparam int OFF_HOST_RX    = 'h14;

  // host receive word: count[24:9], valid[8], data[7:0]
  function automatic logic [WORD_W-1:0] pack_host_rx(input logic valid,
                                                     input logic [BYTE_W-1:0] data,
                                                     input logic [CNT_FIELD_W-1:0] remain);
    if (!valid) return '0;
    return {7'd0, remain, 1'b1, data};
  endfunction

  // host transmit word: can-accept[8], held byte[7:0]
  function automatic logic [WORD_W-1:0] pack_host_tx(input logic can_accept,
                                                     input logic [BYTE_W-1:0] held);
    return {23'd0, can_accept, held};
  endfunction

  // device status word: rx ready[1], tx busy[0]
  function automatic logic [WORD_W-1:0] pack_status(input logic rx_ready,
                                                    input logic tx_busy);
    return {30'd0, rx_ready, tx_busy};
  endfunction

  // occupancy left once the head byte is taken
  function automatic logic [CNT_FIELD_W-1:0] remain_after_pop(input logic [CNT_FIELD_W-1:0] occ);
    return occ - CNT_FIELD_W'(1);
  endfunction
endpackage

// File: rtl/vuart_fifo.sv
module vuart_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [PW-1:0] wr_nxt, rd_nxt;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign head    = mem[rd_ptr];

  generate
    if (DEPTH == 1) begin : g_single
      assign wr_nxt = '0;
      assign rd_nxt = '0;
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_nxt;
      if (pop_ok)  rd_ptr <= rd_nxt;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  // a full queue stays full until something is read out
  p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
  // an empty queue stays empty until something is written
  p_empty_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty);
endmodule

// File: rtl/vuart_dev_regs.sv
module vuart_dev_regs
  import vuart_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic              host_load,
  input  logic [BYTE_W-1:0] host_byte,
  input  logic              q_full,
  output logic              rx_ready,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              push,
  output logic [BYTE_W-1:0] push_byte
);
  logic hit_status, hit_txd, hit_rxd, rx_take;

  assign hit_status = (addr == AW'(OFF_DEV_STATUS));
  assign hit_txd    = (addr == AW'(OFF_DEV_TXD));
  assign hit_rxd    = (addr == AW'(OFF_DEV_RXD));
  assign push       = wr & hit_txd;
  assign push_byte  = wdata;
  assign rx_take    = rd & hit_rxd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_ready <= 1'b0;
      rx_byte  <= '0;
    end else if (host_load) begin
      rx_ready <= 1'b1;
      rx_byte  <= host_byte;
    end else if (rx_take) begin
      rx_ready <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      if (hit_status)   rdata <= pack_status(rx_ready, q_full);
      else if (hit_rxd) rdata <= {{(WORD_W-BYTE_W){1'b0}}, rx_byte};
      else              rdata <= '0;
    end
  end

  p_load_sets_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_load |=> (rx_ready && rx_byte == $past(host_byte)));
  p_take_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_take && !host_load) |=> !rx_ready);
endmodule

// File: rtl/vuart_host_regs.sv
module vuart_host_regs
  import vuart_pkg::*;
#(
  parameter int AW = 5,
  parameter int CW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic              dev_rx_ready,
  input  logic [BYTE_W-1:0] held_byte,
  input  logic [BYTE_W-1:0] q_head,
  input  logic [CW-1:0]     q_count,
  input  logic              q_empty,
  output logic              load,
  output logic [BYTE_W-1:0] load_byte,
  output logic              drop,
  output logic              pop
);
  logic hit_tx, hit_rx;
  logic [CNT_FIELD_W-1:0] occ16;

  assign hit_tx    = (addr == AW'(OFF_HOST_TX));
  assign hit_rx    = (addr == AW'(OFF_HOST_RX));
  assign load      = wr & hit_tx & ~dev_rx_ready;
  assign drop      = wr & hit_tx & dev_rx_ready;
  assign load_byte = wdata;
  assign pop       = rd & hit_rx & ~q_empty;
  assign occ16     = CNT_FIELD_W'(q_count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      if (hit_tx)      rdata <= pack_host_tx(~dev_rx_ready, held_byte);
      else if (hit_rx) rdata <= pack_host_rx(~q_empty, q_head, remain_after_pop(occ16));
      else             rdata <= '0;
    end
  end

  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hit_rx && q_empty) |=> (rdata == '0));
  p_tx_ready_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hit_tx) |=> (rdata[8] == !$past(dev_rx_ready)));
endmodule

// File: rtl/vuart_bridge.sv
module vuart_bridge
  import vuart_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_wr,
  input  logic              dev_rd,
  input  logic [AW-1:0]     dev_addr,
  input  logic [7:0]        dev_wdata,
  output logic [31:0]       dev_rdata,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [AW-1:0]     host_addr,
  input  logic [7:0]        host_wdata,
  output logic [31:0]       host_rdata
);
  localparam int CW = $clog2(DEPTH + 1);

  logic              host_load, host_drop, host_pop;
  logic [BYTE_W-1:0] load_byte, rx_byte, push_byte, q_head;
  logic              rx_ready, dev_push;
  logic              q_full, q_empty, q_push_ok, q_pop_ok;
  logic [CW-1:0]     q_count;

  vuart_dev_regs #(.AW(AW)) u_dev (
    .clk(clk), .rst_n(rst_n), .wr(dev_wr), .rd(dev_rd), .addr(dev_addr),
    .wdata(dev_wdata), .rdata(dev_rdata), .host_load(host_load),
    .host_byte(load_byte), .q_full(q_full), .rx_ready(rx_ready),
    .rx_byte(rx_byte), .push(dev_push), .push_byte(push_byte)
  );

  vuart_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_q (
    .clk(clk), .rst_n(rst_n), .push(dev_push), .din(push_byte),
    .pop(host_pop), .head(q_head), .count(q_count), .full(q_full),
    .empty(q_empty), .push_ok(q_push_ok), .pop_ok(q_pop_ok)
  );

  vuart_host_regs #(.AW(AW), .CW(CW)) u_host (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .rd(host_rd), .addr(host_addr),
    .wdata(host_wdata), .rdata(host_rdata), .dev_rx_ready(rx_ready),
    .held_byte(rx_byte), .q_head(q_head), .q_count(q_count),
    .q_empty(q_empty), .load(host_load), .load_byte(load_byte),
    .drop(host_drop), .pop(host_pop)
  );

  p_drop_keeps_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_drop |=> ($stable(rx_byte) && rx_ready));
  p_count_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop_ok && !q_push_ok) |=> (host_rdata[24:9] == CNT_FIELD_W'(q_count)));
  p_full_drops_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_push && q_full && !host_pop) |=> (q_count == $past(q_count)));
endmodule

// File: tb/vuart_bridge_test.sv
`timescale 1ns/1ps
module vuart_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dev_wr = 0, dev_rd = 0, host_wr = 0, host_rd = 0;
  logic [4:0]  dev_addr = '0, host_addr = '0;
  logic [7:0]  dev_wdata = '0, host_wdata = '0;
  logic [31:0] dev_rdata, host_rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vuart_bridge #(.DEPTH(4), .AW(5)) uut (
    .clk(clk), .rst_n(rst_n), .dev_wr(dev_wr), .dev_rd(dev_rd),
    .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rx_word(input int remain, input logic [7:0] d);
    return (32'(remain) << 9) + 32'h100 + 32'(d);
  endfunction

  task automatic hwr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask
  task automatic hrd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); host_rd = 1; host_addr = a;
    @(negedge clk); host_rd = 0; v = host_rdata;
  endtask
  task automatic dwr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); dev_wr = 1; dev_addr = a; dev_wdata = d;
    @(negedge clk); dev_wr = 0;
  endtask
  task automatic drd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); dev_rd = 1; dev_addr = a;
    @(negedge clk); dev_rd = 0; v = dev_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    drd(5'h00, v); chk("R1 status after reset", v, 32'h0);
    hrd(5'h14, v); chk("R1 host rx after reset", v, 32'h0);
    hrd(5'h10, v); chk("R1 host tx after reset", v, 32'h100);
  endtask

  task automatic t_host_to_dev;
    logic [31:0] v;
    hwr(5'h10, 8'h41);
    drd(5'h00, v); chk("R2 rx ready set", v, 32'h2);
    hrd(5'h10, v); chk("R4 host tx busy view", v, 32'h41);
    drd(5'h0C, v); chk("R4 device reads byte", v, 32'h41);
    drd(5'h00, v); chk("R4 rx ready cleared", v, 32'h0);
    hrd(5'h10, v); chk("R4 host tx ready again", v, 32'h141);
  endtask

  task automatic t_pending_drop;
    logic [31:0] v;
    hwr(5'h10, 8'h55);
    hwr(5'h10, 8'h66);
    drd(5'h0C, v); chk("R3 second write dropped", v, 32'h55);
    drd(5'h00, v); chk("R3 ready cleared after take", v, 32'h0);
  endtask

  task automatic t_fifo_order;
    logic [31:0] v;
    dwr(5'h08, 8'h11); dwr(5'h08, 8'h22); dwr(5'h08, 8'h33);
    hrd(5'h14, v); chk("R6 first pop", v, rx_word(2, 8'h11));
    hrd(5'h14, v); chk("R5 second pop", v, rx_word(1, 8'h22));
    hrd(5'h14, v); chk("R5 third pop", v, rx_word(0, 8'h33));
    hrd(5'h14, v); chk("R7 empty read", v, 32'h0);
    hrd(5'h14, v); chk("R7 empty read repeat", v, 32'h0);
  endtask

  task automatic t_full;
    logic [31:0] v;
    for (int i = 0; i < 4; i++) dwr(5'h08, 8'(8'hA0 + i));
    drd(5'h00, v); chk("R8 busy when full", v, 32'h1);
    dwr(5'h08, 8'h99);
    hrd(5'h14, v); chk("R8 head after drop", v, rx_word(3, 8'hA0));
    drd(5'h00, v); chk("R8 busy cleared", v, 32'h0);
    for (int i = 1; i < 4; i++) begin
      hrd(5'h14, v); chk("R8 drain order", v, rx_word(3 - i, 8'(8'hA0 + i)));
    end
    hrd(5'h14, v); chk("R8 dropped byte absent", v, 32'h0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    dwr(5'h00, 8'hFF); dwr(5'h0C, 8'h77);
    drd(5'h00, v); chk("R9 device writes elsewhere ignored", v, 32'h0);
    hwr(5'h14, 8'h12);
    hrd(5'h14, v); chk("R9 host rx write ignored", v, 32'h0);
    drd(5'h04, v); chk("R9 device unmapped read", v, 32'h0);
    hrd(5'h00, v); chk("R9 host unmapped read", v, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_host_to_dev();
    t_pending_drop();
    t_fifo_order();
    t_full();
    t_map();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule